// File: doc/BRIEF.md
# Condition-Gated ALU Stage with Held Status Flags

This block is a single-issue execute stage. Each instruction it receives carries a 4-bit condition code. That code is evaluated against a stored set of four status flags: negative, zero, carry and overflow. When the condition holds, the ALU result is presented with a one-cycle write strobe for the register file. When the condition does not hold, the instruction is dropped. A dropped instruction writes nothing and changes no flag.

Flag updates are optional. An ordinary operation refreshes the flags only when its set-flags input is high. The four compare and test operations always refresh the flags and never write a result. Because of this, one comparison can steer any number of later conditional instructions.

Each instruction is sampled on a clock edge. Its write strobe, result and new flags appear after that edge. The very next instruction is therefore already evaluated against the updated flags.

Top module: `pred_alu`

## Requirements
- R1: Condition codes that test a single flag pass as follows: 0 when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R2: Compound condition codes pass as follows: 8 when C=1 and Z=0; 9 when C=0 or Z=1; 10 when N equals V; 11 when N differs from V; 12 when Z=0 and N equals V; 13 when Z=1 or N differs from V.
- R3: Code 14 always passes. Code 15 never passes, so the instruction writes nothing and leaves the flags unchanged.
- R4: An instruction whose condition fails leaves `wen_o` low, `res_o` unchanged and `flags_o` unchanged, even when `setf_i` is high.
- R5: A passing opcode 0–8 changes the flags only when `setf_i` is 1. Otherwise the flags keep their value across any number of following instructions.
- R6: Opcodes 9 (AND test), 10 (XOR test), 11 (compare, a−b) and 12 (compare-add, a+b) update the flags whenever they pass, whatever `setf_i` is. They never raise `wen_o`.
- R7: Arithmetic opcodes are 2 (a−b), 3 (b−a) and 4 (a+b). They write the W-bit result. When flags are updated, C is the carry out (no borrow for subtracts) and V is signed overflow.
- R8: Logical opcodes are 0 (a&b), 1 (a^b), 5 (a|b), 6 (b), 7 (a&~b) and 8 (~b). When flags are updated, these and opcodes 9 and 10 set N from the result MSB and Z when the result is zero, and keep C and V.
- R9: The flags are on `flags_o` as {N,Z,C,V} in bits 3..0. Outputs change on the edge after the one that samples the instruction. A back-to-back instruction sees the new flags.
- R10: During reset, `flags_o` is 0, `wen_o` is 0 and `res_o` is 0.
- R11: `res_o` holds its last written value while `wen_o` is low. Opcodes 13–15 and cycles with `vld_i` low write nothing and change no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Instruction present this cycle |
| op_i | input | 4 | Operation code |
| cond_i | input | 4 | Condition code |
| setf_i | input | 1 | Request flag update |
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| res_o | output | W | Last written result |
| wen_o | output | 1 | Register write strobe, one cycle |
| flags_o | output | 4 | Held flags {N,Z,C,V} |

## Verification
Corrupted flag state is visible at once on `flags_o`. On the following cycle it also shows as a wrong write strobe for any conditional instruction whose code depends on the bad flag. The bench therefore brings the flags into each of several distinct states, then sweeps all sixteen condition codes. Each swept instruction carries a distinct operand, so a misjudged condition appears on `wen_o` and `res_o` in the very next cycle. Hidden mistakes in carry or overflow are exposed on the same cycle by compares that straddle the unsigned and signed wrap points.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam logic [3:0] OP_AND = 4'd0;
    localparam logic [3:0] OP_XOR = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_RSB = 4'd3;
    localparam logic [3:0] OP_ADD = 4'd4;
    localparam logic [3:0] OP_ORR = 4'd5;
    localparam logic [3:0] OP_MOV = 4'd6;
    localparam logic [3:0] OP_CLR = 4'd7;
    localparam logic [3:0] OP_NOT = 4'd8;
    localparam logic [3:0] OP_TAND = 4'd9;
    localparam logic [3:0] OP_TXOR = 4'd10;
    localparam logic [3:0] OP_CSUB = 4'd11;
    localparam logic [3:0] OP_CADD = 4'd12;

    localparam logic [3:0] CC_ZS = 4'd0;
    localparam logic [3:0] CC_ZC = 4'd1;
    localparam logic [3:0] CC_CS = 4'd2;
    localparam logic [3:0] CC_CC = 4'd3;
    localparam logic [3:0] CC_NS = 4'd4;
    localparam logic [3:0] CC_NC = 4'd5;
    localparam logic [3:0] CC_VS = 4'd6;
    localparam logic [3:0] CC_VC = 4'd7;
    localparam logic [3:0] CC_UGT = 4'd8;
    localparam logic [3:0] CC_ULE = 4'd9;
    localparam logic [3:0] CC_SGE = 4'd10;
    localparam logic [3:0] CC_SLT = 4'd11;
    localparam logic [3:0] CC_SGT = 4'd12;
    localparam logic [3:0] CC_SLE = 4'd13;
    localparam logic [3:0] CC_ANY = 4'd14;
    localparam logic [3:0] CC_NONE = 4'd15;

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
    import pred_alu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);
    logic sgn_ge;

    always_comb begin
        sgn_ge = (flags_i.n == flags_i.v);
        unique case (cond_i)
            CC_ZS:   pass_o = flags_i.z;
            CC_ZC:   pass_o = !flags_i.z;
            CC_CS:   pass_o = flags_i.c;
            CC_CC:   pass_o = !flags_i.c;
            CC_NS:   pass_o = flags_i.n;
            CC_NC:   pass_o = !flags_i.n;
            CC_VS:   pass_o = flags_i.v;
            CC_VC:   pass_o = !flags_i.v;
            CC_UGT:  pass_o = flags_i.c && !flags_i.z;
            CC_ULE:  pass_o = !flags_i.c || flags_i.z;
            CC_SGE:  pass_o = sgn_ge;
            CC_SLT:  pass_o = !sgn_ge;
            CC_SGT:  pass_o = sgn_ge && !flags_i.z;
            CC_SLE:  pass_o = !sgn_ge || flags_i.z;
            CC_ANY:  pass_o = 1'b1;
            default: pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pred_alu_core.sv
module pred_alu_core
    import pred_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  flags_t       flags_i,
    output logic [W-1:0] res_o,
    output flags_t       flags_o,
    output logic         writes_o,
    output logic         forces_o,
    output logic         legal_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic         add_cin;
    logic [W:0]   add_sum;
    logic         arith;
    logic         ovf;

    always_comb begin
        add_x    = a_i;
        add_y    = ~b_i;
        add_cin  = 1'b1;
        arith    = 1'b0;
        res_o    = '0;
        writes_o = 1'b1;
        forces_o = 1'b0;
        legal_o  = 1'b1;
        unique case (op_i)
            OP_SUB, OP_CSUB: begin
                arith = 1'b1;
            end
            OP_RSB: begin
                add_x = b_i;
                add_y = ~a_i;
                arith = 1'b1;
            end
            OP_ADD, OP_CADD: begin
                add_y   = b_i;
                add_cin = 1'b0;
                arith   = 1'b1;
            end
            default: ;
        endcase
        add_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
        ovf     = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
        unique case (op_i)
            OP_AND, OP_TAND: res_o = a_i & b_i;
            OP_XOR, OP_TXOR: res_o = a_i ^ b_i;
            OP_ORR:          res_o = a_i | b_i;
            OP_MOV:          res_o = b_i;
            OP_CLR:          res_o = a_i & ~b_i;
            OP_NOT:          res_o = ~b_i;
            OP_SUB, OP_RSB, OP_ADD, OP_CSUB, OP_CADD: res_o = add_sum[W-1:0];
            default: begin
                legal_o  = 1'b0;
                writes_o = 1'b0;
            end
        endcase
        if (op_i inside {OP_TAND, OP_TXOR, OP_CSUB, OP_CADD}) begin
            writes_o = 1'b0;
            forces_o = 1'b1;
        end
        flags_o.n = res_o[MSB];
        flags_o.z = (res_o == '0);
        flags_o.c = arith ? add_sum[W] : flags_i.c;
        flags_o.v = arith ? ovf : flags_i.v;
    end
endmodule

// File: rtl/pred_alu.sv
module pred_alu
    import pred_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         vld_i,
    input  logic [3:0]   op_i,
    input  logic [3:0]   cond_i,
    input  logic         setf_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic [W-1:0] res_o,
    output logic         wen_o,
    output logic [3:0]   flags_o
);
    typedef struct packed {
        flags_t       flags;
        logic [W-1:0] res;
        logic         wen;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    logic         pass;
    logic [W-1:0] alu_res;
    flags_t       alu_flags;
    logic         alu_writes;
    logic         alu_forces;
    logic         alu_legal;

    pred_cond_eval u_cond (
        .cond_i  (cond_i),
        .flags_i (st_q.flags),
        .pass_o  (pass)
    );

    pred_alu_core #(.W(W)) u_core (
        .op_i     (op_i),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .flags_i  (st_q.flags),
        .res_o    (alu_res),
        .flags_o  (alu_flags),
        .writes_o (alu_writes),
        .forces_o (alu_forces),
        .legal_o  (alu_legal)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wen = 1'b0;
        if (vld_i && pass && alu_legal) begin
            if (alu_writes) begin
                st_d.wen = 1'b1;
                st_d.res = alu_res;
            end
            if (alu_forces || setf_i) begin
                st_d.flags = alu_flags;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = st_q.res;
    assign wen_o   = st_q.wen;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk #(
    parameter int W = 32
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         vld_i,
    input logic [3:0]   op_i,
    input logic [3:0]   cond_i,
    input logic         setf_i,
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] res_o,
    input logic         wen_o,
    input logic [3:0]   flags_o
);
    // R10
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (flags_o == 4'h0 && !wen_o && res_o == '0));

    // R6
    compare_no_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && op_i inside {4'd9, 4'd10, 4'd11, 4'd12}) |=> !wen_o);

    // R3
    never_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && cond_i == 4'd15) |=> (!wen_o && $stable(flags_o) && $stable(res_o)));

    // R5
    flags_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && !setf_i && op_i <= 4'd8) |=> $stable(flags_o));

    // R11
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !vld_i |=> (!wen_o && $stable(flags_o) && $stable(res_o)));

    // R7
    add_always_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && cond_i == 4'd14 && op_i == 4'd4) |=> (wen_o && res_o == $past(opa_i) + $past(opb_i)));

    // R11
    hold_when_idle_wen_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wen_o |-> !$isunknown(res_o));
endmodule

bind pred_alu pred_alu_chk #(.W(W)) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .vld_i   (vld_i),
    .op_i    (op_i),
    .cond_i  (cond_i),
    .setf_i  (setf_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .res_o   (res_o),
    .wen_o   (wen_o),
    .flags_o (flags_o)
);

// File: tb/pred_alu_tb_top.sv
`timescale 1ns/1ps
module pred_alu_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         vld = 1'b0;
    logic [3:0]   op = 4'd0;
    logic [3:0]   cond = 4'd14;
    logic         setf = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] res;
    logic         wen;
    logic [3:0]   flags;

    always #2 clk = ~clk;

    pred_alu #(.W(W)) dut_i (
        .clk_i (clk), .rst_i (rst), .vld_i (vld), .op_i (op), .cond_i (cond),
        .setf_i (setf), .opa_i (a), .opb_i (b),
        .res_o (res), .wen_o (wen), .flags_o (flags)
    );

    typedef struct {
        logic         wen;
        logic [W-1:0] res;
        logic [3:0]   fl;
        int           cyc;
        string        tag;
    } exp_t;

    exp_t         q[$];
    int           cyc = 0;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 0;
    logic [3:0]   m_fl = 4'h0;
    logic [W-1:0] m_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push(input logic w, input string tag);
        exp_t e;
        e.wen = w; e.res = m_res; e.fl = m_fl; e.cyc = cyc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic issue(input logic [3:0] o, input logic [3:0] c, input logic s,
                         input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
        logic [W:0]   wide;
        logic [W-1:0] r;
        logic         cy, v, arith, wr, upd;
        @(negedge clk);
        vld = 1'b1; op = o; cond = c; setf = s; a = x; b = y;
        arith = 1'b0; cy = m_fl[1]; v = m_fl[0]; r = '0; wr = 1'b1; upd = s;
        case (o)
            4'd0, 4'd9:  r = x & y;
            4'd1, 4'd10: r = x ^ y;
            4'd5: r = x | y;
            4'd6: r = y;
            4'd7: r = x & ~y;
            4'd8: r = ~y;
            4'd2, 4'd11: begin
                wide = {1'b0, x} - {1'b0, y}; r = wide[W-1:0]; cy = (x >= y);
                v = (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]); arith = 1'b1;
            end
            4'd3: begin
                wide = {1'b0, y} - {1'b0, x}; r = wide[W-1:0]; cy = (y >= x);
                v = (x[W-1] != y[W-1]) && (r[W-1] != y[W-1]); arith = 1'b1;
            end
            4'd4, 4'd12: begin
                wide = {1'b0, x} + {1'b0, y}; r = wide[W-1:0]; cy = wide[W];
                v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]); arith = 1'b1;
            end
            default: begin wr = 1'b0; upd = 1'b0; end
        endcase
        if (o >= 4'd9 && o <= 4'd12) begin wr = 1'b0; upd = 1'b1; end
        if (!cond_ok(c, m_fl)) begin wr = 1'b0; upd = 1'b0; end
        if (wr) m_res = r;
        if (upd) m_fl = {r[W-1], (r == '0), cy, v};
        push(wr, tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        vld = 1'b0; setf = 1'b1; op = 4'd4; a = 32'h5; b = 32'h7;
        push(1'b0, tag);
    endtask

    always @(negedge clk) begin
        if (!rst && q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (wen !== e.wen || res !== e.res || flags !== e.fl) begin
                n_bad++;
                $display("FAIL %s: got wen=%0b res=%h flags=%h, expected wen=%0b res=%h flags=%h",
                         e.tag, wen, res, flags, e.wen, e.res, e.fl);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic sweep(input string tag);
        for (int c = 0; c < 16; c++) issue(4'd6, c[3:0], 1'b0, '0, 32'd100 + c, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (flags !== 4'h0 || wen !== 1'b0 || res !== '0) begin
            n_bad++;
            $display("FAIL R10 reset: got wen=%0b res=%h flags=%h, expected 0 0 0", wen, res, flags);
        end
        rst = 1'b0;
        // R1 R2 R3: sweep all conditions under several flag states
        sweep("R1 R2 R3 flags clear");
        issue(4'd11, 4'd14, 1'b0, 32'd5, 32'd5, "R6 compare equal");
        sweep("R1 R2 R3 equal");
        issue(4'd11, 4'd14, 1'b0, 32'd3, 32'd5, "R6 R7 compare less");
        sweep("R1 R2 R3 less");
        issue(4'd11, 4'd14, 1'b0, 32'h8000_0000, 32'd1, "R6 R7 signed wrap");
        sweep("R1 R2 R3 overflow");
        issue(4'd12, 4'd14, 1'b0, 32'hFFFF_FFFF, 32'd1, "R6 R7 compare-add carry");
        sweep("R1 R2 R3 carry zero");
        issue(4'd4, 4'd14, 1'b1, 32'h7FFF_FFFF, 32'd1, "R7 add overflow");
        sweep("R1 R2 R3 neg overflow");
        issue(4'd11, 4'd14, 1'b0, 32'd9, 32'd2, "R6 compare greater");
        sweep("R1 R2 R3 greater");
        // R5: flags held across unflagged ops, shared predication
        issue(4'd4, 4'd14, 1'b0, 32'd1, 32'hFFFF_FFFF, "R5 add no setf");
        issue(4'd2, 4'd8, 1'b0, 32'd50, 32'd8, "R5 sub predicated");
        issue(4'd3, 4'd8, 1'b0, 32'd8, 32'd50, "R5 R7 rsb predicated");
        issue(4'd6, 4'd12, 1'b0, '0, 32'd77, "R5 mov predicated");
        // R4: failing condition with setf
        issue(4'd2, 4'd0, 1'b1, 32'd4, 32'd4, "R4 squashed sub");
        issue(4'd10, 4'd9, 1'b1, 32'd4, 32'd4, "R4 squashed test");
        // R7: arithmetic with flags
        issue(4'd2, 4'd14, 1'b1, 32'd3, 32'd7, "R7 sub borrow");
        issue(4'd3, 4'd14, 1'b1, 32'd3, 32'd7, "R7 rsb");
        issue(4'd2, 4'd14, 1'b1, 32'd7, 32'd7, "R7 sub zero");
        // R8: logical ops keep C and V
        issue(4'd4, 4'd14, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R8 prep VN");
        issue(4'd0, 4'd14, 1'b1, 32'hF0F0_0000, 32'h0F0F_0000, "R8 and zero");
        issue(4'd8, 4'd14, 1'b1, '0, 32'h0000_0001, "R8 not");
        issue(4'd1, 4'd14, 1'b1, 32'h1234, 32'h1234, "R8 xor");
        issue(4'd5, 4'd14, 1'b1, 32'h1, 32'h8000_0000, "R8 orr");
        issue(4'd7, 4'd14, 1'b1, 32'hFF, 32'h0F, "R8 clear bits");
        issue(4'd9, 4'd14, 1'b0, 32'hFF, 32'h100, "R6 R8 and test");
        issue(4'd10, 4'd14, 1'b0, 32'h8000_0000, 32'h1, "R6 R8 xor test");
        // R9: back-to-back flag visibility
        issue(4'd11, 4'd14, 1'b0, 32'd1, 32'd1, "R9 compare");
        issue(4'd6, 4'd0, 1'b0, '0, 32'hAA, "R9 next sees zero");
        issue(4'd11, 4'd14, 1'b0, 32'd1, 32'd2, "R9 compare");
        issue(4'd6, 4'd0, 1'b0, '0, 32'hBB, "R9 next sees nonzero");
        // R11: undefined opcodes and idle cycles
        issue(4'd13, 4'd14, 1'b1, 32'd1, 32'd1, "R11 op13");
        issue(4'd14, 4'd14, 1'b1, '0, '0, "R11 op14");
        issue(4'd15, 4'd14, 1'b1, 32'd9, 32'd9, "R11 op15");
        idle("R11 idle");
        idle("R11 idle");
        issue(4'd6, 4'd15, 1'b1, '0, 32'd1, "R3 never with setf");
        idle("R11 drain");
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            summary();
            $finish;
        end
    end
endmodule